// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Display Driver

This block drives a four-digit common-anode seven-segment display from four 4-bit values packed on one input bus. The digits share the seven segment lines, so only one digit is lit at a time. A free-running up counter paces the refresh. Its two most significant bits pick the digit that owns the current time slot. The chosen nibble is turned into a hexadecimal glyph. The anode strobe and the segment pattern leave the block from the same output register, so they always change together.

Each digit has a blank input. When it is set, that digit stays fully dark for its whole slot. The counter width is a parameter. For hardware it is set so that one full wrap lasts between 1 ms and 16 ms at 100 MHz, which allows widths from 17 to 20; the default of 18 gives a wrap of about 2.6 ms. A simulation can use a much smaller width.

Top module: `seg_mux_display`

## Requirements
- R1: While the synchronous active-high reset is asserted, `an_n` is 4'b1111 and `seg_n` is 7'h7F on the next rising edge. The refresh counter is cleared, so digit 0 owns the first slot after reset.
- R2: The refresh counter advances by one on every clock. It wraps to zero after 2^CNT_W clocks, so the slot pattern repeats with that period.
- R3: On the n-th rising edge after reset is released (n = 1, 2, ...), the outputs show slot ((n-1) mod 2^CNT_W) >> (CNT_W-2). Each slot therefore lasts 2^(CNT_W-2) clocks, and the outputs lag the counter by one register stage.
- R4: While slot s is active and digit s is not blanked, `an_n` equals the bitwise inverse of (1 << s). Anode bit s is the only low bit, and the anode bit index equals the digit index.
- R5: Segments are active low, with `seg_n[0]` = segment a through `seg_n[6]` = segment g. The active-high glyphs (g..a) for values 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71. `seg_n` is the inverse of the glyph.
- R6: While slot s is active and `blank[s]` is 1, `an_n` is 4'b1111 and `seg_n` is 7'h7F.
- R7: Digit s is taken from `digits[4s+3:4s]`. A change on `digits` or `blank` appears on the outputs at the next rising edge.
- R8: At no clock does more than one bit of `an_n` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digits | input | 4*NUM_DIG | Packed hex digits; digit s at bits 4s+3:4s |
| blank | input | NUM_DIG | Per-digit blank; 1 keeps that digit dark |
| an_n | output | NUM_DIG | Active-low anode enables, bit s for digit s |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |

## Verification
The bench builds the driver with CNT_W = 4, so each slot lasts four clocks and a full wrap takes sixteen. Every slot of every wrap can then be checked clock by clock. All sixteen hex values pass through each digit position, and all sixteen blank masks are applied one per wrap. A mid-run reset confirms that the slot order restarts at digit 0.

// File: rtl/seg_mux_pkg.sv
package seg_mux_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SEG_W = 7;

  // Active-high glyph, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/seg_refresh_ctr.sv
module seg_refresh_ctr #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLEAR: assert property (@(posedge clk) rst |=> (cnt_q == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
endmodule

// File: rtl/seg_slot_decode.sv
module seg_slot_decode #(
  parameter int unsigned NUM_DIG = 4,
  localparam int unsigned SEL_W = $clog2(NUM_DIG)
) (
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_DIG-1:0] onehot_o
);
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dec
    assign onehot_o[g] = (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/seg_hex_decode.sv
module seg_hex_decode
  import seg_mux_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SEG_W-1:0] seg_n_o
);
  assign seg_n_o = ~hex_glyph(nib_i);
endmodule

// File: rtl/seg_mux_display.sv
module seg_mux_display
  import seg_mux_pkg::*;
#(
  parameter int unsigned CNT_W   = 18,
  parameter int unsigned NUM_DIG = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_DIG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_DIG*NIB_W-1:0] digits,
  input  logic [NUM_DIG-1:0]       blank,
  output logic [NUM_DIG-1:0]       an_n,
  output logic [SEG_W-1:0]         seg_n
);
  logic [CNT_W-1:0]   cnt;
  logic [SEL_W-1:0]   sel;
  logic [NUM_DIG-1:0] slot_hot;
  logic [NIB_W-1:0]   nib_arr [NUM_DIG];
  logic [NIB_W-1:0]   cur_nib;
  logic [SEG_W-1:0]   seg_w;
  logic [NUM_DIG-1:0] an_q;
  logic [SEG_W-1:0]   seg_q;

  seg_refresh_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .cnt_o(cnt)
  );

  assign sel = cnt[CNT_W-1 -: SEL_W];

  seg_slot_decode #(.NUM_DIG(NUM_DIG)) u_slot (
    .sel_i(sel), .onehot_o(slot_hot)
  );

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_nib
    assign nib_arr[g] = digits[g*NIB_W +: NIB_W];
  end

  assign cur_nib = nib_arr[sel];

  seg_hex_decode u_hex (
    .nib_i(cur_nib), .seg_n_o(seg_w)
  );

  // Anode and segments share one register stage
  always_ff @(posedge clk) begin
    if (rst || blank[sel]) begin
      an_q  <= '1;
      seg_q <= '1;
    end else begin
      an_q  <= ~slot_hot;
      seg_q <= seg_w;
    end
  end

  assign an_n  = an_q;
  assign seg_n = seg_q;

  AST_ONE_ANODE: assert property (@(posedge clk) disable iff (rst)
    $countones(~an_n) <= 1); // R8
  AST_DARK_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (&an_n) |-> (&seg_n)); // R6
  AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(&an_n)) |-> (an_n == ~(NUM_DIG'(1) << $past(sel)))); // R3
  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> ((&an_n) && (&seg_n))); // R1
endmodule

// File: tb/tb_seg_mux_display.sv
module tb_seg_mux_display;
  localparam int CW = 4;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] digits = '0;
  logic [3:0]  blank = '0;
  logic [3:0]  an_n;
  logic [6:0]  seg_n;

  int checks = 0;
  int fails  = 0;
  int n      = 0;

  always #5 clk = ~clk;

  seg_mux_display #(.CNT_W(CW), .NUM_DIG(ND)) dut (
    .clk(clk), .rst(rst), .digits(digits), .blank(blank),
    .an_n(an_n), .seg_n(seg_n)
  );

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%h expected=%h", req, n, act, exp);
    end
  endtask

  // One clock: edge, then sample at the falling edge against the model (R2 R3 R4 R5 R6 R7)
  task automatic step_check();
    int slot;
    logic [3:0] ea;
    logic [6:0] es;
    @(posedge clk);
    n++;
    @(negedge clk);
    slot = ((n - 1) % (1 << CW)) >> (CW - 2);
    if (blank[slot]) begin
      ea = 4'hF; es = 7'h7F;
      chk("R6 anode", {3'b0, an_n}, {3'b0, ea});
      chk("R6 seg", seg_n, es);
    end else begin
      ea = ~(4'b1 << slot);
      es = ~glyph(digits[slot*4 +: 4]);
      chk("R3/R4 anode", {3'b0, an_n}, {3'b0, ea});
      chk("R5/R7 seg", seg_n, es);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 anode", {3'b0, an_n}, 7'h0F);
    chk("R1 seg", seg_n, 7'h7F);
    rst = 1'b0;
    n = 0;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // Every hex value through every digit position, one wrap per pattern
    for (int v = 0; v < 16; v++) begin
      digits = {4'(v + 3), 4'(v + 2), 4'(v + 1), 4'(v)};
      for (int c = 0; c < (1 << CW); c++) step_check();
    end
    // All blank masks, one wrap each
    digits = 16'hC5A9;
    for (int m = 0; m < 16; m++) begin
      blank = 4'(m);
      for (int c = 0; c < (1 << CW); c++) step_check();
    end
    // Input change mid-slot takes effect at the next edge (R7)
    blank = 4'h0;
    for (int c = 0; c < (1 << CW); c++) begin
      digits = {4'(c), 4'(c + 5), 4'(c + 9), 4'(c + 13)};
      step_check();
    end
    // Reset mid-run restarts at digit 0 (R1)
    repeat (5) step_check();
    @(negedge clk);
    do_reset();
    for (int c = 0; c < 2 * (1 << CW); c++) step_check();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule